// File: doc/BRIEF.md
# Pending Exception Priority Resolver

This block chooses, every clock, the single pending exception that should be taken next. It works from a table of vectors, and each vector number has a secure copy and a non-secure copy. Each copy has its own enable bit, its own pending input and its own 8-bit priority. A copy competes only when it is enabled and pending. The winner is the copy with the lowest group priority. A tie on group priority goes to the lower subpriority, then to the lower vector number, and then to the secure copy.

Each bank has its own grouping control, a 3-bit split value `k`. Priority bits `[k:0]` form the subpriority and the bits above them form the group priority. Vector 1 (reset) and vector 2 (non-maskable) have fixed negative priorities. Both are always enabled and are never split. The enable bits live inside the block and come out of reset with a fixed pattern. Per-vector set and clear strobes change them afterwards.

The result is registered. It gives a valid flag, the winning vector number, its group priority and the bank it came from. A core's exception entry logic compares this result against its running priority.

Top module: `pexr_resolver`

## Requirements
- R1: A copy competes only while both its enable bit and its pending input are 1. A pending copy that is disabled never wins, whatever its priority.
- R2: Among competing copies, the lowest group priority wins. Priorities are compared as signed 10-bit values.
- R3: With split `k` (0..7), bits `[k:0]` of the 8-bit priority are the subpriority and the remaining upper bits, kept in place, are the group priority. With k=7 every configurable priority has group priority 0. When group priorities are equal and non-negative, the lower subpriority wins.
- R4: A secure copy is split with `split_s_i` and a non-secure copy with `split_ns_i`. The split of the other bank has no effect.
- R5: On a full tie, the lower vector number wins. If the number is also equal, the secure copy wins over the non-secure copy.
- R6: Vector 1 has fixed priority -3 (-4 when SEC_EXT=1) and vector 2 has fixed priority -2, in both banks. Their priority inputs and the split settings are ignored. They are always enabled, clear strobes have no effect on them, and they are never split by subpriority.
- R7: After reset, vectors 11, 14 and 15 are enabled in both banks. Vector 12 and every vector from 16 upward are disabled.
- R8: A set strobe bit enables that vector in its bank from the next clock edge, and a clear strobe bit disables it. If set and clear arrive together, set wins. Vector 0 never becomes enabled.
- R9: When no copy competes, the outputs are valid=0, number=0, secure flag=0 and priority=256, a sentinel above every legal value. This is also the reset state.
- R10: The outputs are registered. They show the decision made from the pending, priority and split inputs present at the previous rising edge. `win_prio_o` is the group priority (subpriority bits zero, fixed values in two's complement).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_s_i | input | NUM_VEC | Pending flags, secure bank |
| pend_ns_i | input | NUM_VEC | Pending flags, non-secure bank |
| prio_s_i | input | NUM_VEC*8 | Secure priorities, vector v in bits [8v+7:8v] |
| prio_ns_i | input | NUM_VEC*8 | Non-secure priorities, same layout |
| split_s_i | input | 3 | Subpriority split for the secure bank |
| split_ns_i | input | 3 | Subpriority split for the non-secure bank |
| en_set_s_i | input | NUM_VEC | Enable set strobes, secure bank |
| en_clr_s_i | input | NUM_VEC | Enable clear strobes, secure bank |
| en_set_ns_i | input | NUM_VEC | Enable set strobes, non-secure bank |
| en_clr_ns_i | input | NUM_VEC | Enable clear strobes, non-secure bank |
| win_valid_o | output | 1 | A winner exists |
| win_num_o | output | $clog2(NUM_VEC) | Winning vector number |
| win_prio_o | output | 10 | Winner's group priority, signed |
| win_secure_o | output | 1 | Winner is the secure copy |

## Verification
A change on the pending, priority or split inputs shows at the outputs one rising edge later. A set or clear strobe first updates the enable register at one edge, so its effect on the winner appears at the edge after that. The driver changes inputs at the falling edge and queues the expected result at that moment. The monitor pops one entry 1 ns after each following rising edge, so every comparison lands in the cycle where its result is due. Strobe-only steps queue nothing, which keeps the enable latency out of the comparisons.

// File: rtl/pexr_pkg.sv
package pexr_pkg;
    localparam int PRIO_W  = 8;
    localparam int SPLIT_W = $clog2(PRIO_W);
    localparam int SPRIO_W = PRIO_W + 2;

    typedef logic signed [SPRIO_W-1:0] sprio_t;

    // Above every legal priority: reported when nothing competes.
    localparam sprio_t NO_EXC_PRIO = sprio_t'(1 << PRIO_W);

    // Vector numbers whose behaviour is fixed.
    localparam int VEC_RESET  = 1;
    localparam int VEC_NMI    = 2;
    localparam int VEC_SVC    = 11;
    localparam int VEC_DBGMON = 12;
    localparam int VEC_PSV    = 14;
    localparam int VEC_TICK   = 15;

    localparam int NMI_PRIO = -2;
endpackage

// File: rtl/pexr_prio_split.sv
module pexr_prio_split
    import pexr_pkg::*;
#(
    parameter bit FIXED      = 1'b0,
    parameter int FIXED_PRIO = 0
) (
    input  logic [PRIO_W-1:0]  raw_i,
    input  logic [SPLIT_W-1:0] split_i,
    output sprio_t             grp_o,
    output logic [PRIO_W-1:0]  sub_o
);
    generate
        if (FIXED) begin : g_fixed
            // Fixed vectors: negative priority, no subpriority.
            logic unused_in;
            assign unused_in = ^{raw_i, split_i};
            assign grp_o     = sprio_t'(FIXED_PRIO);
            assign sub_o     = '0;
        end else begin : g_cfg
            logic [PRIO_W:0] low_mask;
            logic            unused_top;
            assign low_mask   = ({{PRIO_W{1'b0}}, 1'b1} << ({1'b0, split_i} + 1'b1)) - 1'b1;
            assign unused_top = low_mask[PRIO_W];
            assign sub_o      = raw_i & low_mask[PRIO_W-1:0];
            assign grp_o      = sprio_t'({2'b00, raw_i & ~low_mask[PRIO_W-1:0]});
        end
    endgenerate
endmodule

// File: rtl/pexr_enable_bank.sv
module pexr_enable_bank
    import pexr_pkg::*;
#(
    parameter int NUM_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] set_i,
    input  logic [NUM_VEC-1:0] clr_i,
    output logic [NUM_VEC-1:0] en_o
);
    function automatic logic [NUM_VEC-1:0] one_hot(input int idx);
        logic [NUM_VEC-1:0] m;
        m      = '0;
        m[idx] = 1'b1;
        return m;
    endfunction

    localparam logic [NUM_VEC-1:0] ON_MASK  = one_hot(VEC_RESET) | one_hot(VEC_NMI);
    localparam logic [NUM_VEC-1:0] OFF_MASK = one_hot(0);
    localparam logic [NUM_VEC-1:0] RST_EN   = ON_MASK | one_hot(VEC_SVC)
                                            | one_hot(VEC_PSV) | one_hot(VEC_TICK);

    logic [NUM_VEC-1:0] en_d, en_q;

    always_comb begin
        en_d = (en_q & ~clr_i) | set_i;
        en_d = (en_d | ON_MASK) & ~OFF_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= RST_EN;
        else        en_q <= en_d;
    end

    assign en_o = en_q;

    // R8: a clear without a matching set takes effect at the next edge
    a_r8_clear_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_i & ~set_i & ~ON_MASK)) |=>
        ((en_q & $past(clr_i & ~set_i & ~ON_MASK)) == '0));

    // R8: a set enables the vector at the next edge
    a_r8_set_applies: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & ~OFF_MASK)) |=>
        ((en_q & $past(set_i & ~OFF_MASK)) == $past(set_i & ~OFF_MASK)));
endmodule

// File: rtl/pexr_resolver.sv
module pexr_resolver
    import pexr_pkg::*;
#(
    parameter  int NUM_VEC = 32,
    parameter  bit SEC_EXT = 1'b0,
    localparam int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_VEC-1:0]        pend_s_i,
    input  logic [NUM_VEC-1:0]        pend_ns_i,
    input  logic [NUM_VEC*PRIO_W-1:0] prio_s_i,
    input  logic [NUM_VEC*PRIO_W-1:0] prio_ns_i,
    input  logic [SPLIT_W-1:0]        split_s_i,
    input  logic [SPLIT_W-1:0]        split_ns_i,
    input  logic [NUM_VEC-1:0]        en_set_s_i,
    input  logic [NUM_VEC-1:0]        en_clr_s_i,
    input  logic [NUM_VEC-1:0]        en_set_ns_i,
    input  logic [NUM_VEC-1:0]        en_clr_ns_i,
    output logic                      win_valid_o,
    output logic [IDX_W-1:0]          win_num_o,
    output logic [SPRIO_W-1:0]        win_prio_o,
    output logic                      win_secure_o
);
    localparam int RESET_PRIO = SEC_EXT ? -4 : -3;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] num;
        sprio_t           grp;
        logic             sec;
    } pick_t;

    // Bank 0 is secure, bank 1 non-secure.
    logic [NUM_VEC-1:0]        en_w    [2];
    logic [NUM_VEC-1:0]        pend_w  [2];
    logic [NUM_VEC-1:0]        set_w   [2];
    logic [NUM_VEC-1:0]        clr_w   [2];
    logic [NUM_VEC*PRIO_W-1:0] prio_w  [2];
    logic [SPLIT_W-1:0]        split_w [2];
    sprio_t                    grp_w   [2][NUM_VEC];
    logic [PRIO_W-1:0]         sub_w   [2][NUM_VEC];

    assign pend_w[0]  = pend_s_i;    assign pend_w[1]  = pend_ns_i;
    assign set_w[0]   = en_set_s_i;  assign set_w[1]   = en_set_ns_i;
    assign clr_w[0]   = en_clr_s_i;  assign clr_w[1]   = en_clr_ns_i;
    assign prio_w[0]  = prio_s_i;    assign prio_w[1]  = prio_ns_i;
    assign split_w[0] = split_s_i;   assign split_w[1] = split_ns_i;

    generate
        for (genvar b = 0; b < 2; b++) begin : g_bank
            pexr_enable_bank #(.NUM_VEC(NUM_VEC)) u_en (
                .clk   (clk),
                .rst_n (rst_n),
                .set_i (set_w[b]),
                .clr_i (clr_w[b]),
                .en_o  (en_w[b])
            );
            for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
                localparam bit IS_FIX = (v == VEC_RESET) || (v == VEC_NMI);
                localparam int FIX_P  = (v == VEC_RESET) ? RESET_PRIO : NMI_PRIO;
                pexr_prio_split #(.FIXED(IS_FIX), .FIXED_PRIO(FIX_P)) u_split (
                    .raw_i   (prio_w[b][v*PRIO_W +: PRIO_W]),
                    .split_i (split_w[b]),
                    .grp_o   (grp_w[b][v]),
                    .sub_o   (sub_w[b][v])
                );
            end
        end
    endgenerate

    pick_t st_d, st_q;

    // Scan upward by number, secure copy first; strict less-than replace
    // yields lowest-number then secure-first on full ties.
    always_comb begin
        sprio_t            best_grp;
        logic [PRIO_W-1:0] best_sub;
        best_grp   = NO_EXC_PRIO;
        best_sub   = '0;
        st_d.valid = 1'b0;
        st_d.num   = '0;
        st_d.sec   = 1'b0;
        for (int v = 0; v < NUM_VEC; v++) begin
            for (int b = 0; b < 2; b++) begin
                if (en_w[b][v] && pend_w[b][v]) begin
                    if ((grp_w[b][v] < best_grp) ||
                        ((grp_w[b][v] == best_grp) && !grp_w[b][v][SPRIO_W-1] &&
                         (sub_w[b][v] < best_sub))) begin
                        best_grp   = grp_w[b][v];
                        best_sub   = sub_w[b][v];
                        st_d.valid = 1'b1;
                        st_d.num   = IDX_W'(v);
                        st_d.sec   = (b == 0);
                    end
                end
            end
        end
        st_d.grp = best_grp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{valid: 1'b0, num: '0, grp: NO_EXC_PRIO, sec: 1'b0};
        else        st_q <= st_d;
    end

    assign win_valid_o  = st_q.valid;
    assign win_num_o    = st_q.num;
    assign win_prio_o   = st_q.grp;
    assign win_secure_o = st_q.sec;

    // R9: idle outputs carry the sentinel
    a_r9_idle_sentinel: assert property (@(posedge clk) disable iff (!rst_n)
        !win_valid_o |-> (win_num_o == '0 && win_prio_o == NO_EXC_PRIO && !win_secure_o));

    // R2: a real winner never reports the sentinel
    a_r2_prio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> (win_prio_o != NO_EXC_PRIO));

    // R6: fixed priorities reported for the fixed vectors
    a_r6_reset_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o && win_num_o == IDX_W'(VEC_RESET)) |->
        ($signed(win_prio_o) == SPRIO_W'(RESET_PRIO)));
    a_r6_nmi_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (win_valid_o && win_num_o == IDX_W'(VEC_NMI)) |->
        ($signed(win_prio_o) == SPRIO_W'(NMI_PRIO)));

    // R1: the chosen copy is enabled and pending in its own bank
    a_r1_qualified_s: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d.valid && st_d.sec) |-> (en_w[0][st_d.num] && pend_w[0][st_d.num]));
    a_r1_qualified_ns: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d.valid && !st_d.sec) |-> (en_w[1][st_d.num] && pend_w[1][st_d.num]));
endmodule

// File: tb/tb_pexr_resolver.sv
`timescale 1ns/1ps
module tb_pexr_resolver;
    localparam int N  = 32;
    localparam int PW = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0]    pend_s = '0, pend_ns = '0;
    logic [N*PW-1:0] prio_s = '0, prio_ns = '0;
    logic [2:0]      split_s = '0, split_ns = '0;
    logic [N-1:0]    set_s = '0, clr_s = '0, set_ns = '0, clr_ns = '0;
    logic            w_valid, w_sec;
    logic [IW-1:0]   w_num;
    logic [9:0]      w_prio;

    pexr_resolver #(.NUM_VEC(N), .SEC_EXT(1'b0)) dut (
        .clk(clk), .rst_n(rst_n),
        .pend_s_i(pend_s), .pend_ns_i(pend_ns),
        .prio_s_i(prio_s), .prio_ns_i(prio_ns),
        .split_s_i(split_s), .split_ns_i(split_ns),
        .en_set_s_i(set_s), .en_clr_s_i(clr_s),
        .en_set_ns_i(set_ns), .en_clr_ns_i(clr_ns),
        .win_valid_o(w_valid), .win_num_o(w_num),
        .win_prio_o(w_prio), .win_secure_o(w_sec)
    );

    typedef struct {
        logic       valid;
        int         num;
        logic [9:0] prio;
        logic       sec;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;
    logic [N-1:0] men_s, men_ns;

    function automatic exp_t model();
        exp_t e;
        int   bg, bs;
        bg = 256; bs = 0;
        e.valid = 1'b0; e.num = 0; e.sec = 1'b0;
        for (int i = 1; i < N; i++) begin
            for (int b = 0; b < 2; b++) begin
                logic en, pd;
                int raw, sp, low, g, s;
                en  = (b == 0) ? men_s[i] : men_ns[i];
                pd  = (b == 0) ? pend_s[i] : pend_ns[i];
                raw = (b == 0) ? int'(prio_s[i*PW +: PW]) : int'(prio_ns[i*PW +: PW]);
                sp  = (b == 0) ? int'(split_s) : int'(split_ns);
                if (i == 1 || i == 2) en = 1'b1;
                low = (1 << (sp + 1)) - 1;
                g = raw & ~low & 255; s = raw & low;
                if (i == 1) begin g = -3; s = 0; end
                if (i == 2) begin g = -2; s = 0; end
                if (en && pd && (g < bg || (g == bg && g >= 0 && s < bs))) begin
                    bg = g; bs = s; e.valid = 1'b1; e.num = i; e.sec = (b == 0);
                end
            end
        end
        e.prio = 10'(bg);
        return e;
    endfunction

    task automatic apply(input string req);
        exp_t e;
        e = model();
        e.req = req;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic strobe(input logic [N-1:0] ss, sc, ns, nc);
        set_s = ss; clr_s = sc; set_ns = ns; clr_ns = nc;
        @(negedge clk);
        set_s = '0; clr_s = '0; set_ns = '0; clr_ns = '0;
        men_s  = ((((men_s & ~sc) | ss)) | N'(6)) & ~N'(1);
        men_ns = ((((men_ns & ~nc) | ns)) | N'(6)) & ~N'(1);
    endtask

    task automatic clear_in();
        pend_s = '0; pend_ns = '0; prio_s = '0; prio_ns = '0;
    endtask

    function automatic logic [N-1:0] bit_at(input int i);
        logic [N-1:0] m;
        m = '0; m[i] = 1'b1;
        return m;
    endfunction

    // Monitor: compare one queued item just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_chk++;
                if (w_valid !== e.valid || int'(w_num) != e.num ||
                    w_prio !== e.prio || w_sec !== e.sec) begin
                    n_fail++;
                    $display("FAIL %s actual v=%0b n=%0d p=%h s=%0b expected v=%0b n=%0d p=%h s=%0b",
                             e.req, w_valid, w_num, w_prio, w_sec,
                             e.valid, e.num, e.prio, e.sec);
                end
            end
        end
    end

    initial begin
        #(4 * 20000);
        n_chk++; n_fail++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        men_s  = bit_at(1) | bit_at(2) | bit_at(11) | bit_at(14) | bit_at(15);
        men_ns = men_s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9 reset / idle state read directly
        n_chk++;
        if (w_valid !== 1'b0 || w_num !== '0 || w_prio !== 10'd256 || w_sec !== 1'b0) begin
            n_fail++;
            $display("FAIL R9 reset actual v=%0b n=%0d p=%h expected v=0 n=0 p=100",
                     w_valid, w_num, w_prio);
        end

        apply("R9 nothing pending");

        // R7: vector 12 is disabled out of reset
        pend_s[12] = 1'b1; pend_ns[12] = 1'b1;
        apply("R7 debug monitor disabled");

        // R7: vector 14 enabled out of reset
        clear_in(); pend_s[14] = 1'b1; prio_s[14*PW +: PW] = 8'h40;
        apply("R7 pended-service enabled");

        // R1: disabled vector 20 with best priority loses to 15
        clear_in(); pend_s[20] = 1'b1; pend_s[15] = 1'b1;
        prio_s[15*PW +: PW] = 8'h80;
        apply("R1 disabled candidate ignored");

        // R8 + R2: enable 20,21 secure, lower group wins
        strobe(bit_at(20) | bit_at(21), '0, '0, '0);
        clear_in(); pend_s[20] = 1'b1; pend_s[21] = 1'b1;
        prio_s[20*PW +: PW] = 8'h60; prio_s[21*PW +: PW] = 8'h20;
        apply("R2 lowest group priority");

        // R3: equal group 0x20, subpriority decides
        split_s = 3'd3;
        prio_s[20*PW +: PW] = 8'h25; prio_s[21*PW +: PW] = 8'h23;
        apply("R3 subpriority tie-break");

        // R4: non-secure copy uses its own split
        strobe('0, '0, bit_at(20), '0);
        clear_in(); pend_s[21] = 1'b1; prio_s[21*PW +: PW] = 8'h23;
        pend_ns[20] = 1'b1; prio_ns[20*PW +: PW] = 8'h22;
        apply("R4 per-bank split");

        // R5: lowest number on full tie
        clear_in(); split_s = 3'd0;
        pend_s[20] = 1'b1; pend_s[21] = 1'b1;
        prio_s[20*PW +: PW] = 8'h40; prio_s[21*PW +: PW] = 8'h40;
        apply("R5 lowest number");

        // R5: secure before non-secure on same number
        clear_in(); pend_s[20] = 1'b1; pend_ns[20] = 1'b1;
        prio_s[20*PW +: PW] = 8'h40; prio_ns[20*PW +: PW] = 8'h40;
        apply("R5 secure first");

        // R5: number outranks bank
        clear_in(); pend_ns[20] = 1'b1; pend_s[21] = 1'b1;
        prio_ns[20*PW +: PW] = 8'h40; prio_s[21*PW +: PW] = 8'h40;
        apply("R5 number before bank");

        // R6: reset in both banks plus NMI
        clear_in(); pend_s[1] = 1'b1; pend_ns[1] = 1'b1; pend_ns[2] = 1'b1;
        prio_s[1*PW +: PW] = 8'hFF;
        apply("R6 reset fixed priority");

        // R6: NMI beats priority 0
        clear_in(); pend_ns[2] = 1'b1; pend_s[14] = 1'b1;
        apply("R6 nmi fixed priority");

        // R8: clear S21, set+clear NS21 (set wins), clear on vector 1 ignored
        strobe('0, bit_at(21) | bit_at(1), bit_at(21), bit_at(21));
        clear_in(); pend_s[21] = 1'b1; pend_ns[21] = 1'b1; pend_s[15] = 1'b1;
        prio_s[21*PW +: PW] = 8'h10; prio_ns[21*PW +: PW] = 8'h10;
        prio_s[15*PW +: PW] = 8'h80;
        apply("R8 clear applied, set wins");

        clear_in(); pend_s[1] = 1'b1;
        apply("R8 fixed vector ignores clear");

        // R3 boundary: split 7 leaves group 0
        clear_in(); split_s = 3'd7; split_ns = 3'd0;
        pend_s[20] = 1'b1; prio_s[20*PW +: PW] = 8'hF0;
        pend_ns[14] = 1'b1; prio_ns[14*PW +: PW] = 8'h01;
        apply("R3 split seven");

        // R1 + R10: only disabled vectors pending, back to back with above
        clear_in(); pend_ns[19:16] = 4'hF; pend_s[31] = 1'b1;
        apply("R10 back-to-back idle");

        @(posedge clk); #2;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule